// File: doc/BRIEF.md
# Debug-Port Key Unlock Gate

This block decides, once per power-on, whether a debug monitor may see the contents of the protected on-chip memory. After power-on reset it takes key bytes from a byte-wide receive handshake. It compares each byte, as it arrives, with a stored eight-byte key. Once the eighth byte is in, whatever the outcome, it asks the serial transmitter for a break character to show that the monitor is ready for commands. If every byte matched, it raises the unlocked flag.

The block sits between the processor's bus and the memory array. A locked block replaces every data read from the protected range with the constant 0x00. It also turns every instruction fetch from that range into an illegal-address reset request. The stored key lives in non-volatile-style registers that neither reset clears. It is loaded through a write port at the key addresses. A mass-erase input sets the whole key to 0xFF, so a later power-on attempt with eight 0xFF bytes unlocks the part. Only a power-on reset opens a new key-entry window. The system reset does not.

Top module: `dbg_key_gate`

## Requirements
- R1: While and just after `por_n` is low, `key_unlocked`, `brk_req` and `ill_addr_rst` are 0.
- R2: `brk_req` stays 0 until eight key bytes (`rx_valid` high for one cycle each, with any idle gaps between them) have been accepted since power-on reset, whether or not they match.
- R3: In the cycle after the eighth byte is accepted, `brk_req` is 1 for exactly one cycle. No further request follows before or after `brk_ack`, and bytes received after the eighth are ignored.
- R4: Key byte number i (i = 0..7, in arrival order) is compared with the stored byte at address 0xFFF6+i. When all eight match, `key_unlocked` is 1 from the cycle after the eighth byte, and a read of address 0x0080 returns 0x40 (bit 6 = unlocked; all other bits 0).
- R5: While `key_unlocked` is 0, `bus_rdata` is 0x00 for any `bus_addr` at or above 0xEE00. Below 0xEE00 (except 0x0080), and everywhere once unlocked, `bus_rdata` equals `mem_rdata`.
- R6: While locked, `bus_fetch` with `bus_addr` at or above 0xEE00 makes `ill_addr_rst` 1 in the following cycle. A fetch below 0xEE00, or any fetch while unlocked, leaves it 0.
- R7: A low pulse on `rst_n` neither changes `key_unlocked` nor re-opens key entry: bytes received afterwards cause no break request and no unlock.
- R8: A single mismatching byte at any of the eight positions leaves `key_unlocked` at 0 for the rest of the power-on period.
- R9: `key_erase` sets all eight stored key bytes to 0xFF and takes priority over a simultaneous key write. Stored key bytes survive power-on reset.
- R10: `key_wr_en` with `key_wr_addr` in 0xFFF6..0xFFFD stores `key_wr_data` as key byte `key_wr_addr`-0xFFF6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | System reset, synchronous, active low; clears only the trap request |
| rx_valid | input | 1 | Key byte present this cycle |
| rx_data | input | 8 | Key byte |
| brk_req | output | 1 | One-cycle request to send a break character |
| brk_ack | input | 1 | Transmitter accepted the break request |
| key_unlocked | output | 1 | All eight key bytes matched |
| bus_addr | input | 16 | Bus address for read or fetch |
| bus_fetch | input | 1 | Current access is an instruction fetch |
| mem_rdata | input | 8 | Data from the memory array at `bus_addr` |
| bus_rdata | output | 8 | Gated read data |
| ill_addr_rst | output | 1 | Illegal-address reset request |
| key_wr_en | input | 1 | Write strobe for the stored key |
| key_wr_addr | input | 16 | Write address; only 0xFFF6..0xFFFD is stored |
| key_wr_data | input | 8 | Write data |
| key_erase | input | 1 | Mass erase: stored key becomes all 0xFF |

## Verification
Several rules are checked by the bound assertions on every cycle: the unlocked flag only ever rises, the break request is a single-cycle pulse that never appears before eight bytes have been seen, locked reads of the protected range return zero, the status address reports the flag, and a locked protected fetch raises the trap request one cycle later. Only the bench's scenarios can show that the decision is right. It runs a mismatch at each of the eight byte positions with varied gaps, correct keys for two different stored values, and the erase-then-all-0xFF recovery. It also shows that a system reset does not re-open key entry and that erase wins over a simultaneous key write.

// File: rtl/dkg_pkg.sv
// Package: shared types and constants for the debug-port key unlock gate.
// Assumes an 8-bit data path; the address width is set at the top level.
package dkg_pkg;

    // Sequencer states for one power-on key-entry window
    typedef enum logic [1:0] {
        ST_COLLECT  = 2'd0,   // taking key bytes
        ST_BREAK    = 2'd1,   // one-cycle break request
        ST_WAIT_ACK = 2'd2,   // waiting for the transmitter to accept
        ST_OPEN     = 2'd3    // decision taken, window closed
    } seq_state_t;

    localparam logic [7:0] BLANK_BYTE   = 8'hFF;
    localparam logic [7:0] INVALID_BYTE = 8'h00;

endpackage

// File: rtl/dkg_key_store.sv
// Module: stored key bank. Holds KEY_LEN bytes at KEY_BASE..KEY_BASE+KEY_LEN-1.
// It models non-volatile contents, so no reset touches it. Erase blanks every
// byte and overrides a write in the same cycle.
// Assumes KEY_LEN is a power of two so the read index covers the bank exactly.
module dkg_key_store #(
    parameter int              AW       = 16,
    parameter int              KEY_LEN  = 8,
    parameter logic [AW-1:0]   KEY_BASE = 16'hFFF6,
    localparam int             IW       = $clog2(KEY_LEN)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          erase,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);
    import dkg_pkg::*;

    logic [7:0] key_q [KEY_LEN];

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_slot
        localparam logic [AW-1:0] SLOT_ADDR = AW'(KEY_BASE + AW'(g));

        // Purpose: update one key byte from erase or a matching write
        always_ff @(posedge clk) begin
            if (erase) begin
                key_q[g] <= BLANK_BYTE;
            end else if (wr_en && (wr_addr == SLOT_ADDR)) begin
                key_q[g] <= wr_data;
            end
        end
    end

    // Purpose: present the byte the sequencer is comparing against
    assign rd_byte = key_q[rd_idx];

endmodule

// File: rtl/dkg_seq.sv
// Module: key-entry sequencer. It counts KEY_LEN received bytes after power-on
// reset and keeps a sticky mismatch flag. It then pulses a break request and
// waits for the acknowledge. The unlock decision is latched when the last byte
// arrives. Only por_n restarts it.
module dkg_seq #(
    parameter int  KEY_LEN = 8,
    localparam int IW      = $clog2(KEY_LEN)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic [7:0]    key_byte,
    output logic [IW-1:0] key_idx,
    input  logic          brk_ack,
    output logic          brk_req,
    output logic          unlocked
);
    import dkg_pkg::*;

    localparam logic [IW-1:0] LAST_IDX = IW'(KEY_LEN - 1);

    seq_state_t    state_q;
    logic [IW-1:0] idx_q;
    logic          fail_q;
    logic          unlocked_q;
    logic          byte_bad;

    // Purpose: compare the incoming byte with the stored byte at the same position
    assign byte_bad = (rx_data != key_byte);

    // Purpose: walk the key-entry window and latch the decision
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q    <= ST_COLLECT;
            idx_q      <= '0;
            fail_q     <= 1'b0;
            unlocked_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_COLLECT: begin
                    if (rx_valid) begin
                        fail_q <= fail_q | byte_bad;
                        if (idx_q == LAST_IDX) begin
                            state_q    <= ST_BREAK;
                            unlocked_q <= ~(fail_q | byte_bad);
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_BREAK:    state_q <= brk_ack ? ST_OPEN : ST_WAIT_ACK;
                ST_WAIT_ACK: if (brk_ack) state_q <= ST_OPEN;
                ST_OPEN:     state_q <= ST_OPEN;
                default:     state_q <= ST_OPEN;
            endcase
        end
    end

    assign key_idx  = idx_q;
    assign brk_req  = (state_q == ST_BREAK);
    assign unlocked = unlocked_q;

endmodule

// File: rtl/dkg_access_gate.sv
// Module: bus access gate. It answers the status address with the unlock flag,
// replaces protected read data with a constant while locked, and registers an
// illegal-address reset request for a locked fetch from the protected range.
// Assumes the protected range runs from PROT_BASE to the top of the address space.
module dkg_access_gate #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] PROT_BASE = 16'hEE00,
    parameter logic [AW-1:0] STAT_ADDR = 16'h0080,
    parameter int            STAT_BIT  = 6
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          unlocked,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_fetch,
    input  logic [7:0]    mem_rdata,
    output logic [7:0]    bus_rdata,
    output logic          ill_addr_rst
);
    import dkg_pkg::*;

    logic       in_prot;
    logic [7:0] stat_byte;
    logic       trap_q;

    assign in_prot = (bus_addr >= PROT_BASE);

    // Purpose: build the read-only status byte
    always_comb begin
        stat_byte           = '0;
        stat_byte[STAT_BIT] = unlocked;
    end

    // Purpose: select status, invalid constant or array data for a read
    always_comb begin
        if (bus_addr == STAT_ADDR) begin
            bus_rdata = stat_byte;
        end else if (in_prot && !unlocked) begin
            bus_rdata = INVALID_BYTE;
        end else begin
            bus_rdata = mem_rdata;
        end
    end

    // Purpose: register the illegal-address reset request for a locked protected fetch
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            trap_q <= 1'b0;
        end else begin
            trap_q <= bus_fetch && in_prot && !unlocked;
        end
    end

    assign ill_addr_rst = trap_q;

endmodule

// File: rtl/dbg_key_gate.sv
// Module: top of the debug-port key unlock gate. It joins the key store, the
// key-entry sequencer and the bus access gate. Two resets: por_n restarts key
// entry, while rst_n only clears the trap request and leaves the decision alone.
module dbg_key_gate #(
    parameter int            AW        = 16,
    parameter int            KEY_LEN   = 8,
    parameter logic [AW-1:0] KEY_BASE  = 16'hFFF6,
    parameter logic [AW-1:0] PROT_BASE = 16'hEE00,
    parameter logic [AW-1:0] STAT_ADDR = 16'h0080,
    parameter int            STAT_BIT  = 6
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          brk_req,
    input  logic          brk_ack,
    output logic          key_unlocked,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_fetch,
    input  logic [7:0]    mem_rdata,
    output logic [7:0]    bus_rdata,
    output logic          ill_addr_rst,
    input  logic          key_wr_en,
    input  logic [AW-1:0] key_wr_addr,
    input  logic [7:0]    key_wr_data,
    input  logic          key_erase
);
    localparam int IW = $clog2(KEY_LEN);

    logic [IW-1:0] key_idx;
    logic [7:0]    key_byte;

    dkg_key_store #(.AW(AW), .KEY_LEN(KEY_LEN), .KEY_BASE(KEY_BASE)) u_store (
        .clk     (clk),
        .wr_en   (key_wr_en),
        .wr_addr (key_wr_addr),
        .wr_data (key_wr_data),
        .erase   (key_erase),
        .rd_idx  (key_idx),
        .rd_byte (key_byte)
    );

    dkg_seq #(.KEY_LEN(KEY_LEN)) u_seq (
        .clk      (clk),
        .por_n    (por_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .key_byte (key_byte),
        .key_idx  (key_idx),
        .brk_ack  (brk_ack),
        .brk_req  (brk_req),
        .unlocked (key_unlocked)
    );

    dkg_access_gate #(.AW(AW), .PROT_BASE(PROT_BASE), .STAT_ADDR(STAT_ADDR),
                      .STAT_BIT(STAT_BIT)) u_gate (
        .clk          (clk),
        .por_n        (por_n),
        .rst_n        (rst_n),
        .unlocked     (key_unlocked),
        .bus_addr     (bus_addr),
        .bus_fetch    (bus_fetch),
        .mem_rdata    (mem_rdata),
        .bus_rdata    (bus_rdata),
        .ill_addr_rst (ill_addr_rst)
    );

endmodule

// File: rtl/dkg_chk.sv
// Module: assertion checker for dbg_key_gate, attached by bind below.
// Keeps its own count of received bytes to judge when a break is allowed.
module dkg_chk #(
    parameter logic [15:0] PROT_BASE = 16'hEE00,
    parameter logic [15:0] STAT_ADDR = 16'h0080
) (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        brk_req,
    input logic        key_unlocked,
    input logic [15:0] bus_addr,
    input logic        bus_fetch,
    input logic [7:0]  mem_rdata,
    input logic [7:0]  bus_rdata,
    input logic        ill_addr_rst
);
    logic [3:0] seen_q;

    // Purpose: count received bytes since power-on, saturating at eight
    always_ff @(posedge clk) begin
        if (!por_n)                          seen_q <= '0;
        else if (rx_valid && seen_q != 4'd8) seen_q <= seen_q + 4'd1;
    end

    a_r1_quiet_in_por: assert property (@(posedge clk)
        !por_n |=> (!key_unlocked && !brk_req && !ill_addr_rst));

    a_r2_no_early_break: assert property (@(posedge clk) disable iff (!por_n)
        brk_req |-> (seen_q == 4'd8));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
        brk_req |=> !brk_req);

    a_r4_status_bit: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == STAT_ADDR) |-> (bus_rdata == {1'b0, key_unlocked, 6'b0}));

    a_r5_locked_read_zero: assert property (@(posedge clk) disable iff (!por_n)
        (!key_unlocked && bus_addr >= PROT_BASE) |-> (bus_rdata == 8'h00));

    a_r5_open_read_pass: assert property (@(posedge clk) disable iff (!por_n)
        (key_unlocked && bus_addr >= PROT_BASE) |-> (bus_rdata == mem_rdata));

    a_r6_fetch_trap: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!key_unlocked && bus_fetch && bus_addr >= PROT_BASE) |=> ill_addr_rst);

    a_r7_no_relock: assert property (@(posedge clk) disable iff (!por_n)
        key_unlocked |=> key_unlocked);

endmodule

bind dbg_key_gate dkg_chk #(.PROT_BASE(PROT_BASE), .STAT_ADDR(STAT_ADDR)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .brk_req      (brk_req),
    .key_unlocked (key_unlocked),
    .bus_addr     (bus_addr),
    .bus_fetch    (bus_fetch),
    .mem_rdata    (mem_rdata),
    .bus_rdata    (bus_rdata),
    .ill_addr_rst (ill_addr_rst)
);

// File: tb/dbg_key_gate_test.sv
`timescale 1ns/1ps
// Bench: sweeps a mismatch through every key position, checks correct keys for
// two stored values, and checks erase recovery and the system-reset behaviour.
module dbg_key_gate_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b1;
    logic        rx_valid = 1'b0, brk_ack = 1'b0, bus_fetch = 1'b0;
    logic [7:0]  rx_data = '0, key_wr_data = '0;
    logic        key_wr_en = 1'b0, key_erase = 1'b0;
    logic [15:0] bus_addr = 16'h0000, key_wr_addr = '0;
    logic [7:0]  mem_rdata, bus_rdata;
    logic        brk_req, key_unlocked, ill_addr_rst;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [7:0] stored [8];
    logic [7:0] sendk  [8];

    always #2.5 clk = ~clk;

    assign mem_rdata = bus_addr[7:0] ^ bus_addr[15:8];

    dbg_key_gate uut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_por();
        @(negedge clk) por_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 unlocked in por", {15'd0, key_unlocked}, 16'd0);
        chk("R1 brk in por", {15'd0, brk_req}, 16'd0);
        chk("R1 trap in por", {15'd0, ill_addr_rst}, 16'd0);
        por_n = 1'b1;
    endtask

    task automatic program_key();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            key_wr_en = 1'b1; key_wr_addr = 16'hFFF6 + 16'(i); key_wr_data = stored[i];
        end
        @(negedge clk);
        key_wr_en = 1'b1; key_wr_addr = 16'hFFF5; key_wr_data = 8'h5A;   // R10 outside range
        @(negedge clk) key_wr_en = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
        @(negedge clk) rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a; #1;
        chk(tag, {8'd0, bus_rdata}, {8'd0, exp});
    endtask

    task automatic fetch_chk(input string tag, input logic [15:0] a, input logic exp);
        @(negedge clk) begin bus_fetch = 1'b1; bus_addr = a; end
        @(negedge clk) chk(tag, {15'd0, ill_addr_rst}, {15'd0, exp});
        bus_fetch = 1'b0;
        @(negedge clk) chk({tag, " release"}, {15'd0, ill_addr_rst}, 16'd0);
    endtask

    // One key-entry window with the bytes in sendk; ok is the expected outcome
    task automatic attempt(input logic ok, input int gap);
        for (int i = 0; i < 7; i++) begin
            send_byte(sendk[i], gap);
            chk("R2 no break before eighth", {15'd0, brk_req}, 16'd0);
        end
        send_byte(sendk[7], 0);
        chk("R3 break after eighth", {15'd0, brk_req}, 16'd1);
        chk(ok ? "R4 unlocked on match" : "R8 locked on mismatch", {15'd0, key_unlocked}, {15'd0, ok});
        rd_chk("R4 status byte", 16'h0080, ok ? 8'h40 : 8'h00);
        @(negedge clk) chk("R3 pulse one cycle", {15'd0, brk_req}, 16'd0);
        send_byte(sendk[0], 0);
        chk("R3 extra byte ignored", {15'd0, brk_req}, 16'd0);
        chk("R3 extra byte keeps flag", {15'd0, key_unlocked}, {15'd0, ok});
        brk_ack = 1'b1;
        @(negedge clk) brk_ack = 1'b0;
        @(negedge clk) chk("R3 no request after ack", {15'd0, brk_req}, 16'd0);
        for (int a = 0; a < 4; a++) begin
            logic [15:0] pa = (a == 0) ? 16'hEE00 : (a == 1) ? 16'hFFF6 : (a == 2) ? 16'hFFFF : 16'hF123;
            rd_chk("R5 protected read", pa, ok ? (pa[7:0] ^ pa[15:8]) : 8'h00);
        end
        rd_chk("R5 open read below", 16'hEDFF, 8'hED ^ 8'hFF);
        rd_chk("R5 open read low", 16'h1234, 8'h12 ^ 8'h34);
        fetch_chk("R6 protected fetch", 16'hFFF8, !ok);
        fetch_chk("R6 unprotected fetch", 16'h2000, 1'b0);
        // R7: system reset must not reopen key entry
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R7 flag kept over rst_n", {15'd0, key_unlocked}, {15'd0, ok});
        for (int i = 0; i < 8; i++) begin
            send_byte(stored[i], 0);
            chk("R7 no break after rst_n", {15'd0, brk_req}, 16'd0);
        end
        chk("R7 decision unchanged", {15'd0, key_unlocked}, {15'd0, ok});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) stored[i] = 8'h3C + 8'(i * 27);
        program_key();
        do_por();
        for (int i = 0; i < 8; i++) sendk[i] = stored[i];
        attempt(1'b1, 1);
        // R8: one corrupted byte at each position, with varying gaps
        for (int p = 0; p < 8; p++) begin
            do_por();
            for (int i = 0; i < 8; i++) sendk[i] = stored[i];
            sendk[p] = stored[p] ^ (8'h01 << p);
            attempt(1'b0, p % 3);
        end
        // R10: a second key value
        for (int i = 0; i < 8; i++) stored[i] = 8'hA5 ^ 8'(i * 19 + 1);
        program_key();
        do_por();
        for (int i = 0; i < 8; i++) sendk[i] = stored[i];
        attempt(1'b1, 2);
        // R9: erase beats a same-cycle write; the old key then fails, all-0xFF passes
        @(negedge clk) begin
            key_erase = 1'b1; key_wr_en = 1'b1; key_wr_addr = 16'hFFF6; key_wr_data = 8'h12;
        end
        @(negedge clk) begin key_erase = 1'b0; key_wr_en = 1'b0; end
        do_por();
        attempt(1'b0, 0);
        for (int i = 0; i < 8; i++) stored[i] = 8'hFF;
        do_por();
        for (int i = 0; i < 8; i++) sendk[i] = 8'hFF;
        attempt(1'b1, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule